// File: doc/BRIEF.md
# LAPD Signalling-Channel Frame Receiver

This block takes the serial bit stream of a 16 kbit/s signalling channel and recovers LAPD frames from it. A bit is presented on `bit_in` together with a one-cycle `bit_en` strobe. The block finds frame boundaries from the flag pattern and removes the zeros that the sender inserted. It checks the 16-bit frame check sequence, recognises abort sequences and places the accepted octets of each frame in a 32-byte FIFO. The two FCS octets are not stored.

The first two octets of a frame carry the SAPI (with the C/R bit) and the TEI. They are compared against four programmable two-byte address pairs, and each pair has its own enable. A frame that no enabled pair claims is dropped silently. If two complete packets are already waiting in the FIFO when a third one begins, the third is dropped and a lost-packet status is raised.

A host programs the pairs through a small write port. It reads sticky status bits that report how each packet ended, and it drains the FIFO one octet at a time. A marker on the FIFO output flags the final octet of each packet.

Top module: `hdlc_lapd_rx`

## Requirements
- R1: A frame lies between two 01111110 flags, and its octets are assembled LSB first. When a frame is at least 4 octets long, ends on an octet boundary and passes its check, all of its octets except the final two go into the FIFO in order. `fifo_last` is 1 only on the final stored octet, and status bit 0 (good end) is set.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed before the bits are assembled into octets.
- R3: The check uses x^16+x^12+x^5+1, preset to all ones and processed LSB first over every octet including the FCS. A good frame leaves a remainder of 0xF0B8. Any other remainder, or an end that is not on an octet boundary, sets status bit 1 and stores nothing.
- R4: Seven consecutive 1s inside a frame that has received at least one octet form an abort. The abort sets status bit 2, discards the partial packet, and the receiver waits for the next flag.
- R5: Config register 2i holds the first address octet of pair i and register 2i+1 holds the second (i = 0..3). Register 8 bits [3:0] enable pairs 0..3. With no pair enabled, every frame is accepted. With any pair enabled, a frame whose first two octets match no enabled pair stores nothing and raises no status.
- R6: When a frame accepted through a match ends good, status bit 4 (valid address) is set and bits [6:5] give the matching pair's index. The lowest index wins when several pairs match. Bits [6:5] are 0 whenever bit 4 is 0.
- R7: The FIFO holds 32 octets and is read with `fifo_rd`. A frame that would write past 32 stored octets is discarded and sets status bit 3.
- R8: If two complete packets are held in the FIFO when the address of a third accepted frame completes, the third is discarded and status bit 3 (packet lost) is set. The held packets are kept.
- R9: A frame with fewer than 4 octets between its flags is dropped without raising any status.
- R10: All status bits are 0 after reset and are cleared by a one-cycle `stat_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Strobe marking a valid line bit |
| bit_in | input | 1 | Received line bit |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config register index |
| cfg_wdata | input | 8 | Config write data |
| stat_clr | input | 1 | Clears all status bits |
| fifo_rd | input | 1 | Pops the head octet of the FIFO |
| fifo_data | output | 8 | Head octet of the FIFO |
| fifo_last | output | 1 | Head octet ends its packet |
| fifo_empty | output | 1 | No committed octet in the FIFO |
| status | output | 7 | Sticky status: 0 good, 1 FCS error, 2 abort, 3 lost, 4 valid address, 6:5 pair index |

## Verification
The packet-lost case is the hardest one to reach from the ports. It needs two complete packets sitting unread in the FIFO at the moment a third frame's address completes. The bench therefore sends three short good frames back to back without popping anything. It then drains the FIFO and counts the end markers, which shows that exactly two packets survived intact.

The overflow path is reached in a similar way. A single accepted frame longer than the FIFO is sent and stores nothing. Aborts are produced by cutting a frame off with raw 1s that bypass the bench's own zero insertion.

// File: rtl/hdlc_lapd_rx.sv
module hdlc_lapd_rx #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       cfg_we,
  input  logic [3:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       stat_clr,
  input  logic       fifo_rd,
  output logic [7:0] fifo_data,
  output logic       fifo_last,
  output logic       fifo_empty,
  output logic [6:0] status
);
  localparam int AW = $clog2(DEPTH);
  localparam int NPAIR = 4;
  localparam logic [AW:0] FULLCNT = (AW+1)'(DEPTH);

  logic [7:0] pa [NPAIR];
  logic [7:0] pb [NPAIR];
  logic [NPAIR-1:0] pen;
  logic [7:0] mem [DEPTH];
  logic [DEPTH-1:0] lastm;
  logic [AW:0] wps, wpc, rp;
  logic [1:0] pkts, idx, hit_i;
  logic in_frame, drop, hit_any;
  logic [2:0] ones, bitcnt, nbytes;
  logic [7:0] sh, b0, d1, d2;
  logic [15:0] crc;

  function automatic logic [15:0] crc8(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  wire flag_ev  = bit_en && !bit_in && ones == 3'd6;
  wire stuff_ev = bit_en && !bit_in && ones == 3'd5;
  wire abort_ev = bit_en && bit_in && ones == 3'd6;
  wire data_ev  = bit_en && in_frame && !flag_ev && !stuff_ev && !abort_ev;
  wire byte_ev  = data_ev && bitcnt == 3'd7;
  wire [7:0] nb = {bit_in, sh[7:1]};
  wire full     = (wps - rp) == FULLCNT;
  wire wr       = byte_ev && nbytes >= 3'd2 && !drop && !full;
  wire accept   = pen == '0 || hit_any;
  wire closing  = flag_ev && in_frame && nbytes == 3'd4 && !drop;
  wire good_end = closing && bitcnt == 3'd7 && crc == 16'hF0B8;
  wire rd_ok    = fifo_rd && !fifo_empty;
  wire pop_end  = rd_ok && fifo_last;

  assign fifo_empty = wpc == rp;
  assign fifo_data  = mem[rp[AW-1:0]];
  assign fifo_last  = lastm[rp[AW-1:0]];

  always_comb begin
    hit_any = 1'b0;
    hit_i = '0;
    for (int i = NPAIR-1; i >= 0; i--)
      if (pen[i] && pa[i] == b0 && pb[i] == nb) begin
        hit_any = 1'b1;
        hit_i = 2'(i);
      end
  end

  always_ff @(posedge clk)
    if (wr) mem[wps[AW-1:0]] <= d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) begin
        pa[i] <= '0;
        pb[i] <= '0;
      end
      pen <= '0; lastm <= '0; wps <= '0; wpc <= '0; rp <= '0; pkts <= '0;
      idx <= '0; in_frame <= 1'b0; drop <= 1'b0; ones <= '0; bitcnt <= '0;
      nbytes <= '0; sh <= '0; b0 <= '0; d1 <= '0; d2 <= '0; crc <= '1;
      status <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_addr < 4'(2*NPAIR)) begin
          if (cfg_addr[0]) pb[cfg_addr[2:1]] <= cfg_wdata;
          else pa[cfg_addr[2:1]] <= cfg_wdata;
        end else if (cfg_addr == 4'(2*NPAIR)) pen <= cfg_wdata[NPAIR-1:0];
      end
      if (stat_clr) status <= '0;
      if (bit_en) ones <= bit_in ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      if (rd_ok) rp <= rp + 1'b1;
      pkts <= pkts + {1'b0, good_end} - {1'b0, pop_end};
      if (wr) lastm[wps[AW-1:0]] <= 1'b0;

      if (flag_ev) begin
        if (good_end) begin
          wpc <= wps;
          lastm[AW'(wps - 1'b1)] <= 1'b1;
          status[0] <= 1'b1;
          if (pen != '0) begin
            status[4] <= 1'b1;
            status[6:5] <= idx;
          end
        end else begin
          wps <= wpc;
          if (closing) status[1] <= 1'b1;
        end
        in_frame <= 1'b1; bitcnt <= '0; nbytes <= '0; crc <= '1; drop <= 1'b0;
      end else if (abort_ev && in_frame) begin
        wps <= wpc;
        if (nbytes != '0 && !drop) status[2] <= 1'b1;
        in_frame <= 1'b0;
      end else if (data_ev) begin
        sh <= nb;
        bitcnt <= bitcnt + 3'd1;
        if (byte_ev) begin
          if (nbytes != 3'd4) nbytes <= nbytes + 3'd1;
          crc <= crc8(crc, nb);
          d1 <= nb;
          d2 <= d1;
          if (nbytes == 3'd0) b0 <= nb;
          if (nbytes == 3'd1) begin
            if (!accept) drop <= 1'b1;
            else if (pkts == 2'd2) begin
              drop <= 1'b1;
              status[3] <= 1'b1;
            end else idx <= hit_i;
          end
          if (nbytes >= 3'd2 && !drop) begin
            if (full) begin
              drop <= 1'b1;
              wps <= wpc;
              status[3] <= 1'b1;
            end else wps <= wps + 1'b1;
          end
        end
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) (wps - rp) <= FULLCNT);
  // R8
  pkt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) pkts <= 2'd2);
  // R1
  empty_pkts_chk: assert property (@(posedge clk) disable iff (!rst_n) fifo_empty == (pkts == 2'd0));
  // R4
  abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n) (abort_ev && in_frame) |=> !in_frame);
  // R6
  idx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) !status[4] |-> status[6:5] == 2'd0);
endmodule

// File: tb/test_hdlc_lapd_rx.sv
module test_hdlc_lapd_rx;
  logic clk = 0, rst_n = 0, bit_en = 0, bit_in = 1, cfg_we = 0, stat_clr = 0, fifo_rd = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] fifo_data;
  logic fifo_last, fifo_empty;
  logic [6:0] status;
  int checks = 0, errors = 0, ones1 = 0;
  logic [7:0] fr [40];
  int fn = 0;
  logic [7:0] got [40];
  int gn = 0, glast = 0, lastpos = 0;

  hdlc_lapd_rx i_hdlc_lapd_rx (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1;
    @(negedge clk); bit_en = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_flag();
    send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(1);
    send_bit(0);
    ones1 = 0;
  endtask

  task automatic send_dbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i]);
      if (v[i]) begin
        ones1++;
        if (ones1 == 5) begin send_bit(0); ones1 = 0; end
      end else ones1 = 0;
    end
  endtask

  task automatic send_frame(input logic [15:0] corrupt);
    logic [15:0] c = 16'hFFFF;
    send_flag();
    for (int i = 0; i < fn; i++) begin send_dbyte(fr[i]); c = crc_upd(c, fr[i]); end
    c = ~c ^ corrupt;
    send_dbyte(c[7:0]);
    send_dbyte(c[15:8]);
    send_flag();
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    gn = 0; glast = 0; lastpos = -1;
    while (!fifo_empty && gn < 40) begin
      got[gn] = fifo_data;
      if (fifo_last) begin glast++; lastpos = gn; end
      gn++;
      fifo_rd = 1; @(negedge clk); fifo_rd = 0; @(negedge clk);
    end
  endtask

  task automatic clr();
    @(negedge clk); stat_clr = 1; @(negedge clk); stat_clr = 0;
  endtask

  task automatic cfg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic check_data(input string tag);
    chk({tag, " count"}, gn, fn);
    for (int i = 0; i < fn; i++) chk({tag, " byte"}, got[i], fr[i]);
    chk({tag, " last"}, lastpos, fn - 1);
  endtask

  task automatic t_reset();
    chk("R10 reset status", status, 0);
    chk("R7 reset empty", fifo_empty, 1);
  endtask

  task automatic t_good();
    fn = 5; fr[0] = 8'h02; fr[1] = 8'h03; fr[2] = 8'h11; fr[3] = 8'h22; fr[4] = 8'h33;
    send_frame(0);
    chk("R1 good status", status, 7'h01);
    drain(); check_data("R1");
    clr();
  endtask

  task automatic t_stuff();
    fn = 5; fr[0] = 8'h3F; fr[1] = 8'h01; fr[2] = 8'hFF; fr[3] = 8'h7E; fr[4] = 8'hF8;
    send_frame(0);
    chk("R2 status", status, 7'h01);
    drain(); check_data("R2");
    clr();
  endtask

  task automatic t_fcs();
    fn = 4; fr[0] = 8'h02; fr[1] = 8'h03; fr[2] = 8'hA5; fr[3] = 8'h5A;
    send_frame(16'h0010);
    chk("R3 fcs status", status, 7'h02);
    chk("R3 discarded", fifo_empty, 1);
    clr();
  endtask

  task automatic t_abort();
    send_flag();
    send_dbyte(8'h02); send_dbyte(8'h03); send_dbyte(8'h44); send_dbyte(8'h55);
    for (int i = 0; i < 8; i++) send_bit(1);
    send_flag();
    repeat (3) @(negedge clk);
    chk("R4 abort status", status, 7'h04);
    chk("R4 discarded", fifo_empty, 1);
    clr();
  endtask

  task automatic t_short();
    send_flag();
    send_dbyte(8'h02); send_dbyte(8'h03); send_dbyte(8'h44);
    send_flag();
    repeat (3) @(negedge clk);
    chk("R9 short status", status, 0);
    chk("R9 short empty", fifo_empty, 1);
  endtask

  task automatic t_filter();
    cfg(4'd4, 8'h40); cfg(4'd5, 8'h05); cfg(4'd8, 8'h04);
    fn = 3; fr[0] = 8'h40; fr[1] = 8'h07; fr[2] = 8'h99;
    send_frame(0);
    chk("R5 mismatch status", status, 0);
    chk("R5 mismatch empty", fifo_empty, 1);
    fr[1] = 8'h05;
    send_frame(0);
    chk("R6 match pair2 status", status, 7'h51);
    drain(); check_data("R5 match");
    clr();
    cfg(4'd2, 8'h40); cfg(4'd3, 8'h05); cfg(4'd8, 8'h06);
    send_frame(0);
    chk("R6 lowest index status", status, 7'h31);
    drain();
    cfg(4'd8, 8'h00);
    clr();
  endtask

  task automatic t_lost();
    fn = 4; fr[0] = 8'h02; fr[1] = 8'h03; fr[2] = 8'h10; fr[3] = 8'h20;
    send_frame(0); send_frame(0); send_frame(0);
    chk("R8 lost status", status, 7'h09);
    drain();
    chk("R8 kept bytes", gn, 8);
    chk("R8 kept packets", glast, 2);
    chk("R8 byte", got[7], 8'h20);
    clr();
  endtask

  task automatic t_overflow();
    fn = 35;
    for (int i = 0; i < 35; i++) fr[i] = 8'(i + 1);
    send_frame(0);
    chk("R7 overflow status", status, 7'h08);
    chk("R7 overflow empty", fifo_empty, 1);
    fn = 32;
    send_frame(0);
    drain();
    chk("R7 full frame status", status, 7'h09);
    check_data("R7 full");
    clr();
    chk("R10 cleared", status, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) send_bit(1);
    t_good();
    t_stuff();
    t_fcs();
    t_abort();
    t_short();
    t_filter();
    t_lost();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule